// File: doc/BRIEF.md
# Power Mode and FIFO Gate Error Status Byte

This block assembles a read-only 8-bit status byte for a sensor front end. It combines three things: the power mode reported by an external sleep/wake controller, a sticky flag that records a FIFO gate error, and a saturating 5-bit count of output-data-rate ticks since that flag was raised.

A single-cycle detect pulse raises the flag. The flag and its count stay set until the FIFO reports empty, which clears both together. The mode input passes through a register and a legalizing encoder, so an unused mode code never reaches the byte. Reading the byte has no effect on it: the host bus samples `status_byte` as a plain level.

Top module: `gate_err_status`

## Requirements
- R1: The status byte has the error flag at bit 7, the tick count at bits 6:2 and the mode code at bits 1:0.
- R2: The mode field shows, one clock after sampling, the mode input encoded as 00 standby, 01 wake, 10 sleep.
- R3: Mode input 11 is reported as 00 (standby), and the mode field never shows 11.
- R4: While `rst` is high at a clock edge, the byte becomes 0x00 on that edge.
- R5: A cycle with `gerr_pulse` high and `fifo_empty` low sets the flag on the next edge, with the count at 0.
- R6: While the flag is set and `fifo_empty` is low, each `rate_tick` cycle adds one to the count. The tick in the same cycle as the raising pulse is not counted.
- R7: The count stops at 31 and does not wrap.
- R8: A gate error pulse while the flag is already set leaves the count unchanged, apart from any tick in that same cycle.
- R9: A cycle with `fifo_empty` high clears both the flag and the count on the next edge.
- R10: When `fifo_empty` and `gerr_pulse` are high in the same cycle, the flag ends clear.
- R11: While the flag is clear, ticks do not move the count from 0.
- R12: Mode changes do not disturb the flag or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_in | input | 2 | Mode from the sleep/wake controller (00 standby, 01 wake, 10 sleep) |
| rate_tick | input | 1 | One-cycle pulse per output-data-rate period |
| gerr_pulse | input | 1 | One-cycle gate error detect |
| fifo_empty | input | 1 | FIFO has drained |
| status_byte | output | 8 | Packed status: flag, count, mode |

## Verification
A vector table drives these input patterns:
- a mode sweep that includes the illegal code, which separates correct encoding and legalization from a pass-through;
- ticks with the flag clear and ticks with it set, which separate gated counting from free running;
- a repeat error pulse while the flag is set, which shows whether the count restarts;
- a simultaneous drain and error, which shows which of the two has priority.

Directed runs then apply 40 ticks to reach saturation, which separates saturation from wrap-around, and assert reset in the middle of an error episode.

// File: rtl/gate_err_status_pkg.sv
package gate_err_status_pkg;

    localparam int CNT_W  = 5;
    localparam int MODE_W = 2;
    localparam int BYTE_W = 1 + CNT_W + MODE_W;

    typedef enum logic [MODE_W-1:0] {
        PM_STANDBY = 2'b00,
        PM_WAKE    = 2'b01,
        PM_SLEEP   = 2'b10
    } pwr_mode_e;

    typedef struct packed {
        logic             err_flag;
        logic [CNT_W-1:0] ticks;
        pwr_mode_e        mode;
    } status_t;

    function automatic pwr_mode_e legalize_mode(input logic [MODE_W-1:0] raw);
        case (raw)
            2'b01:   return PM_WAKE;
            2'b10:   return PM_SLEEP;
            default: return PM_STANDBY;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input status_t s);
        return {s.err_flag, s.ticks, s.mode};
    endfunction

endpackage

// File: rtl/gate_err_mode_reg.sv
module gate_err_mode_reg
    import gate_err_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_raw,
    output pwr_mode_e         mode_q
);
    always_ff @(posedge clk) begin
        if (rst) mode_q <= PM_STANDBY;
        else     mode_q <= legalize_mode(mode_raw);
    end
endmodule

// File: rtl/gate_err_tracker.sv
module gate_err_tracker #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         err_det,
    input  logic         drained,
    output logic         flag_q,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic         flag_d;
    logic [W-1:0] cnt_d;

    always_comb begin
        flag_d = flag_q;
        cnt_d  = cnt_q;
        if (drained) begin
            flag_d = 1'b0;
            cnt_d  = '0;
        end else if (flag_q) begin
            if (tick && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        end else if (err_det) begin
            flag_d = 1'b1;
            cnt_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            flag_q <= flag_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/gate_err_status.sv
module gate_err_status
    import gate_err_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              rate_tick,
    input  logic              gerr_pulse,
    input  logic              fifo_empty,
    output logic [BYTE_W-1:0] status_byte
);
    pwr_mode_e        mode_q;
    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;
    status_t          st;

    gate_err_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_raw (mode_in),
        .mode_q   (mode_q)
    );

    gate_err_tracker #(.W(CNT_W)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .tick    (rate_tick),
        .err_det (gerr_pulse),
        .drained (fifo_empty),
        .flag_q  (flag_q),
        .cnt_q   (cnt_q)
    );

    always_comb begin
        st.err_flag = flag_q;
        st.ticks    = cnt_q;
        st.mode     = mode_q;
    end

    assign status_byte = pack_status(st);
endmodule

// File: rtl/gate_err_status_chk.sv
module gate_err_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_in,
    input logic       rate_tick,
    input logic       gerr_pulse,
    input logic       fifo_empty,
    input logic [7:0] status_byte
);
    a_r3_no_mode_11: assert property (@(posedge clk) disable iff (rst)
        status_byte[1:0] != 2'b11);

    a_r2_mode_follow: assert property (@(posedge clk) disable iff (rst)
        (mode_in != 2'b11) |=> status_byte[1:0] == $past(mode_in));

    a_r5_set_flag: assert property (@(posedge clk) disable iff (rst)
        (gerr_pulse && !fifo_empty) |=> status_byte[7]);

    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (status_byte[7] && rate_tick && !fifo_empty && status_byte[6:2] != 5'd31)
        |=> status_byte[6:2] == $past(status_byte[6:2]) + 5'd1);

    a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
        (status_byte[6:2] == 5'd31 && !fifo_empty) |=> status_byte[6:2] == 5'd31);

    a_r9_drain_clears: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> status_byte[7:2] == 6'd0);

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && gerr_pulse) |=> !status_byte[7]);

    a_r11_idle_count: assert property (@(posedge clk) disable iff (rst)
        !status_byte[7] |-> status_byte[6:2] == 5'd0);
endmodule

bind gate_err_status gate_err_status_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_in     (mode_in),
    .rate_tick   (rate_tick),
    .gerr_pulse  (gerr_pulse),
    .fifo_empty  (fifo_empty),
    .status_byte (status_byte)
);

// File: tb/gate_err_status_tb_top.sv
`timescale 1ns/1ps
module gate_err_status_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_in = 2'b00;
    logic       rate_tick = 1'b0;
    logic       gerr_pulse = 1'b0;
    logic       fifo_empty = 1'b0;
    logic [7:0] status_byte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gate_err_status dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_in     (mode_in),
        .rate_tick   (rate_tick),
        .gerr_pulse  (gerr_pulse),
        .fifo_empty  (fifo_empty),
        .status_byte (status_byte)
    );

    // {mode, tick, gerr, empty, expected byte}
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b0, 1'b0, 8'h01},  // R2 wake
        {2'b10, 1'b0, 1'b1, 1'b0, 8'h82},  // R5 raise, R2 sleep
        {2'b10, 1'b1, 1'b0, 1'b0, 8'h86},  // R6 count 1
        {2'b10, 1'b1, 1'b1, 1'b0, 8'h8A},  // R8 no restart, count 2
        {2'b11, 1'b0, 1'b0, 1'b0, 8'h88},  // R3 illegal -> standby, R12
        {2'b01, 1'b1, 1'b0, 1'b0, 8'h8D},  // R6 count 3, R1 packing
        {2'b01, 1'b1, 1'b1, 1'b1, 8'h01},  // R10 clear wins, R9
        {2'b01, 1'b1, 1'b0, 1'b0, 8'h01},  // R11 tick with flag clear
        {2'b00, 1'b1, 1'b1, 1'b0, 8'h80},  // R6 raising tick not counted
        {2'b00, 1'b0, 1'b0, 1'b1, 8'h00}   // R9 drain
    };

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (status_byte !== exp) begin
            failures++;
            $display("FAIL %s: status_byte=%h expected=%h", req, status_byte, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic t, input logic g, input logic e);
        mode_in = m; rate_tick = t; gerr_pulse = g; fifo_empty = e;
        @(posedge clk);
        @(negedge clk);
        rate_tick = 1'b0; gerr_pulse = 1'b0; fifo_empty = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R4", 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8]);
            check($sformatf("R1/vec%0d", i), VEC[i][7:0]);
        end

        // R7 saturation
        step(2'b00, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 40; k++) step(2'b00, 1'b1, 1'b0, 1'b0);
        check("R7", 8'hFC);
        step(2'b10, 1'b1, 1'b1, 1'b0);
        check("R7 R8", 8'hFE);
        // R12: mode changes alone keep flag and count
        step(2'b01, 1'b0, 1'b0, 1'b0);
        check("R12", 8'hFD);
        step(2'b00, 1'b0, 1'b0, 1'b1);
        check("R9", 8'h00);

        // R4: reset mid-episode
        step(2'b10, 1'b0, 1'b1, 1'b0);
        step(2'b10, 1'b1, 1'b0, 1'b0);
        check("R6", 8'h86);
        rst = 1'b1;
        step(2'b10, 1'b1, 1'b0, 1'b0);
        check("R4", 8'h00);
        rst = 1'b0;
        step(2'b10, 1'b1, 1'b0, 1'b0);
        check("R11", 8'h02);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule